// File: doc/BRIEF.md
# DRAM ECC Error Capture Registers

This block sits beside a memory controller's ECC checker and records what went wrong. The checker sends a one-cycle pulse for each correctable (single-bit) error and each uncorrectable (multi-bit) error. With each pulse it also presents the failing address, the DRAM channel and the ECC syndrome. Three other conditions also arrive as one-cycle pulses: a refresh timeout, a locked access aimed at memory that is not DRAM, and a thermal sensor trip.

Each condition sets a sticky status bit. Software clears a status bit by writing 1 to it. The location of the error is kept in three registers:

- an address pointer, which holds the address at 128-byte grain with the channel in its low bit;
- an extension register, which holds address bit 32;
- a syndrome register.

A correctable error is logged only when no ECC error is already held. An uncorrectable error replaces any correctable-error record, so the more serious event is the one that stays visible.

A command register selects which status bits drive a registered system-error output. Software reaches every register through a plain synchronous port. Writes take effect at the clock edge. Read data appears on the cycle after the read strobe and is held until the next read.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr_o` is low.
- R2: The status register bits are set as follows. A correctable pulse sets bit 0. An uncorrectable pulse sets bit 1. A refresh-timeout pulse sets bit 8. A non-DRAM lock pulse sets bit 9. A thermal pulse sets bit 11. All other status bits always read 0.
- R3: A write to the status register clears each bit in mask 0x0B03 where the write data holds 1. Bits written with 0 keep their value.
- R4: If a clear write and a new event for the same bit fall in the same cycle, the bit ends up set.
- R5: A correctable error taken while status bits 0 and 1 are both clear loads three registers:
  - the pointer, as {addr[31:7], six zero bits, channel};
  - the extension register, as {7 zero bits, addr[32]};
  - the syndrome register.
- R6: A correctable error that arrives while status bit 0 or bit 1 is set sets bit 0 but leaves the pointer, extension and syndrome registers unchanged.
- R7: An uncorrectable error that arrives while status bit 1 is clear loads the pointer, extension and syndrome registers, even over a held correctable record. This also applies when both pulses arrive together. An uncorrectable error that arrives while bit 1 is set leaves them unchanged.
- R8: The command register stores only the bits of mask 0x0B03; its other bits read 0. `serr_o` equals the OR over (status AND command) as it stood one clock earlier.
- R9: The register offsets are: status 0, command 1, pointer 2, extension 3, syndrome 4. A read strobe returns the addressed register on the next cycle, and the data is held until the next strobe. Offsets 5 to 7 read 0. Writes to offsets 2 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_pulse | input | 1 | Correctable ECC error event |
| ue_pulse | input | 1 | Uncorrectable ECC error event |
| fail_addr | input | 33 | Failing physical address |
| fail_chan | input | 1 | Channel of the failing access |
| fail_syn | input | 8 | ECC syndrome of the failing access |
| rfsh_to_pulse | input | 1 | Refresh timeout event |
| lock_nd_pulse | input | 1 | Locked access to non-DRAM memory event |
| therm_pulse | input | 1 | Thermal sensor event |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_ofs | input | 3 | Register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| serr_o | output | 1 | Registered system-error indication |

## Verification
The hardest situation to reach from the ports is an uncorrectable error landing while a correctable record is held. The bench also has to show that a later correctable error neither replaces that record nor the uncorrectable record that follows it. The directed stimulus builds this step by step: a correctable error, then a second correctable error with a different address, then an uncorrectable error, then a further uncorrectable error. The pointer, extension and syndrome registers are read back after each step. Two collision cases are also driven directly: a clear write in the same cycle as a new event, and correctable and uncorrectable pulses arriving together. A long randomized phase then mixes events, clears, command writes and reads against the reference model.

// File: rtl/ecc_log_pkg.sv
// Shared constants for the ECC error capture registers.
// Assumes a 16-bit status/command layout and 3-bit register offsets.
package ecc_log_pkg;

    localparam int          ST_W     = 16;
    localparam int          OFS_W    = 3;
    localparam logic [15:0] ERR_MASK = 16'h0B03;

    // Status bit positions; software decodes these, so they are fixed.
    localparam int B_CE    = 0;
    localparam int B_UE    = 1;
    localparam int B_RFSH  = 8;
    localparam int B_LOCK  = 9;
    localparam int B_THERM = 11;

    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS = 3'd0,
        OFS_CMD    = 3'd1,
        OFS_PTR    = 3'd2,
        OFS_EXT    = 3'd3,
        OFS_SYN    = 3'd4
    } reg_ofs_e;

endpackage

// File: rtl/ecc_log_status.sv
// Sticky status register with write-one-to-clear bits.
// Assumes event pulses and clear masks are aligned to clk; a set beats a clear.
module ecc_log_status
    import ecc_log_pkg::*;
#(
    parameter logic [ST_W-1:0] MASK = ERR_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] ev,
    input  logic [ST_W-1:0] clr,
    output logic [ST_W-1:0] st_q
);

    logic [ST_W-1:0] st_d;

    // Next state: drop cleared bits, then OR in new events, all inside the mask.
    always_comb begin
        st_d = ((st_q & ~clr) | ev) & MASK;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ecc_log_capture.sv
// Captures address, channel and syndrome of the logged ECC error.
// Assumes ce_held/ue_held reflect status before this cycle's write.
module ecc_log_capture #(
    parameter int ADDR_W    = 33,
    parameter int SYN_W     = 8,
    parameter int GRAIN_LSB = 7,
    parameter int PTR_W     = 32,
    parameter int EXT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_ev,
    input  logic              ue_ev,
    input  logic              ce_held,
    input  logic              ue_held,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chan,
    input  logic [SYN_W-1:0]  syn,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [EXT_W-1:0]  ext_q,
    output logic [SYN_W-1:0]  syn_q
);

    localparam int XB = ADDR_W - PTR_W;

    logic             take;
    logic [PTR_W-1:0] ptr_d;
    logic [EXT_W-1:0] ext_d;

    // Decide whether this cycle's event owns the capture registers.
    always_comb begin
        take = (ue_ev && !ue_held) ||
               (ce_ev && !ue_ev && !ce_held && !ue_held);
    end

    // Format the pointer and extension from the failing address.
    always_comb begin
        ptr_d = {addr[PTR_W-1:GRAIN_LSB], {(GRAIN_LSB-1){1'b0}}, chan};
        ext_d = {{(EXT_W-XB){1'b0}}, addr[ADDR_W-1:PTR_W]};
    end

    // Capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ext_q <= '0;
            syn_q <= '0;
        end else if (take) begin
            ptr_q <= ptr_d;
            ext_q <= ext_d;
            syn_q <= syn;
        end
    end

endmodule

// File: rtl/ecc_log_cmd.sv
// Command (enable) register and registered system-error output.
// Assumes status is already masked; reserved command bits are never stored.
module ecc_log_cmd
    import ecc_log_pkg::*;
#(
    parameter logic [ST_W-1:0] MASK = ERR_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wdata,
    input  logic [ST_W-1:0] st,
    output logic [ST_W-1:0] cmd_q,
    output logic            serr_q
);

    // Command register: keeps only the maskable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= '0;
        else if (wr_en) cmd_q <= wdata & MASK;
    end

    // System-error flop: any enabled status bit raises it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_q <= 1'b0;
        else        serr_q <= |(st & cmd_q & MASK);
    end

endmodule

// File: rtl/ecc_log_rdmux.sv
// Register read multiplexer with one-cycle registered data.
// Assumes a read strobe samples register values from before any same-cycle write.
module ecc_log_rdmux
    import ecc_log_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 32,
    parameter int EXT_W  = 8,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [ST_W-1:0]   st,
    input  logic [ST_W-1:0]   cmd,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [EXT_W-1:0]  ext,
    input  logic [SYN_W-1:0]  syn,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] sel;

    // Pick the addressed register; unmapped offsets return zero.
    always_comb begin
        case (reg_ofs_e'(ofs))
            OFS_STATUS: sel = DATA_W'(st);
            OFS_CMD:    sel = DATA_W'(cmd);
            OFS_PTR:    sel = DATA_W'(ptr);
            OFS_EXT:    sel = DATA_W'(ext);
            OFS_SYN:    sel = DATA_W'(syn);
            default:    sel = '0;
        endcase
    end

    // Read data register, updated only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= sel;
    end

endmodule

// File: rtl/ecc_err_log.sv
// DRAM ECC error capture register block (top).
// Assumes single-cycle event pulses and a simple synchronous register port.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int SYN_W     = 8,
    parameter int GRAIN_LSB = 7,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic              fail_chan,
    input  logic [SYN_W-1:0]  fail_syn,
    input  logic              rfsh_to_pulse,
    input  logic              lock_nd_pulse,
    input  logic              therm_pulse,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              serr_o
);

    localparam int PTR_W = DATA_W;
    localparam int EXT_W = 8;

    logic [ST_W-1:0]  ev;
    logic [ST_W-1:0]  clr;
    logic [ST_W-1:0]  st_q;
    logic [ST_W-1:0]  cmd_q;
    logic [PTR_W-1:0] ptr_q;
    logic [EXT_W-1:0] ext_q;
    logic [SYN_W-1:0] syn_q;
    logic             cmd_wr;

    // Map event pulses onto their status bit positions.
    always_comb begin
        ev          = '0;
        ev[B_CE]    = ce_pulse;
        ev[B_UE]    = ue_pulse;
        ev[B_RFSH]  = rfsh_to_pulse;
        ev[B_LOCK]  = lock_nd_pulse;
        ev[B_THERM] = therm_pulse;
    end

    // Decode register writes into a clear mask and a command load.
    always_comb begin
        clr    = (cfg_wr && reg_ofs_e'(cfg_ofs) == OFS_STATUS) ?
                 (cfg_wdata[ST_W-1:0] & ERR_MASK) : '0;
        cmd_wr = cfg_wr && reg_ofs_e'(cfg_ofs) == OFS_CMD;
    end

    ecc_log_status #(.MASK(ERR_MASK)) u_status (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev),
        .clr  (clr),
        .st_q (st_q)
    );

    ecc_log_capture #(
        .ADDR_W   (ADDR_W),
        .SYN_W    (SYN_W),
        .GRAIN_LSB(GRAIN_LSB),
        .PTR_W    (PTR_W),
        .EXT_W    (EXT_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_ev  (ce_pulse),
        .ue_ev  (ue_pulse),
        .ce_held(st_q[B_CE]),
        .ue_held(st_q[B_UE]),
        .addr   (fail_addr),
        .chan   (fail_chan),
        .syn    (fail_syn),
        .ptr_q  (ptr_q),
        .ext_q  (ext_q),
        .syn_q  (syn_q)
    );

    ecc_log_cmd #(.MASK(ERR_MASK)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cmd_wr),
        .wdata (cfg_wdata[ST_W-1:0]),
        .st    (st_q),
        .cmd_q (cmd_q),
        .serr_q(serr_o)
    );

    ecc_log_rdmux #(
        .DATA_W(DATA_W),
        .PTR_W (PTR_W),
        .EXT_W (EXT_W),
        .SYN_W (SYN_W)
    ) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (cfg_rd),
        .ofs    (cfg_ofs),
        .st     (st_q),
        .cmd    (cmd_q),
        .ptr    (ptr_q),
        .ext    (ext_q),
        .syn    (syn_q),
        .rdata_q(cfg_rdata)
    );

endmodule

// File: rtl/ecc_log_chk.sv
// Assertion checker for ecc_err_log, attached by bind.
// Assumes the bound signal names of the top module.
module ecc_log_chk #(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_pulse,
    input logic              ue_pulse,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              fail_chan,
    input logic              cfg_wr,
    input logic [2:0]        cfg_ofs,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              serr_o,
    input logic [15:0]       st_q,
    input logic [15:0]       cmd_q,
    input logic [DATA_W-1:0] ptr_q
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~16'h0B03) == 16'h0); // R2

    AST_CE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |=> st_q[0]); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_ofs == 3'd0 && cfg_wdata[0] && !ce_pulse) |=> !st_q[0]); // R3

    AST_CE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse && !ue_pulse && (st_q[1:0] != 2'b00)) |=> $stable(ptr_q)); // R6

    AST_UE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_pulse && !st_q[1]) |=>
            (ptr_q[31:GRAIN_LSB] == $past(fail_addr[31:GRAIN_LSB]) &&
             ptr_q[0] == $past(fail_chan))); // R7

    AST_SERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q & cmd_q)) |=> serr_o); // R8

endmodule

bind ecc_err_log ecc_log_chk #(
    .ADDR_W   (ADDR_W),
    .GRAIN_LSB(GRAIN_LSB),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_pulse (ce_pulse),
    .ue_pulse (ue_pulse),
    .fail_addr(fail_addr),
    .fail_chan(fail_chan),
    .cfg_wr   (cfg_wr),
    .cfg_ofs  (cfg_ofs),
    .cfg_wdata(cfg_wdata),
    .serr_o   (serr_o),
    .st_q     (st_q),
    .cmd_q    (cmd_q),
    .ptr_q    (ptr_q)
);

// File: tb/ecc_err_log_bench.sv
// Self-checking bench: behavioural reference model compared every clock.
module ecc_err_log_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 0, ue = 0, rf = 0, lk = 0, th = 0;
    logic [32:0] addr = '0;
    logic        chan = 0;
    logic [7:0]  syn = '0;
    logic        wr = 0, rd = 0;
    logic [2:0]  ofs = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        serr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    logic [15:0] m_st = '0, m_cmd = '0;
    logic [31:0] m_ptr = '0, m_rd = '0;
    logic [7:0]  m_ext = '0, m_syn = '0;
    logic        m_serr = 0;

    always #(PERIOD/2) clk = ~clk;

    ecc_err_log u_ecc_err_log (
        .clk(clk), .rst_n(rst_n),
        .ce_pulse(ce), .ue_pulse(ue),
        .fail_addr(addr), .fail_chan(chan), .fail_syn(syn),
        .rfsh_to_pulse(rf), .lock_nd_pulse(lk), .therm_pulse(th),
        .cfg_wr(wr), .cfg_rd(rd), .cfg_ofs(ofs), .cfg_wdata(wdata),
        .cfg_rdata(rdata), .serr_o(serr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: advance the model from the current inputs, then compare.
    task automatic step(input string tag);
        logic [15:0] ev, clr, n_st, n_cmd;
        logic [31:0] n_ptr, n_rd;
        logic [7:0]  n_ext, n_syn;
        logic        take;
        ev = 16'(ce) | (16'(ue) << 1) | (16'(rf) << 8) | (16'(lk) << 9) | (16'(th) << 11);
        clr = (wr && ofs == 3'd0) ? (wdata[15:0] & 16'h0B03) : 16'h0;
        n_st = (m_st & ~clr) | ev;
        n_cmd = (wr && ofs == 3'd1) ? (wdata[15:0] & 16'h0B03) : m_cmd;
        take = (ue && !m_st[1]) || (ce && !ue && m_st[1:0] == 2'b00);
        n_ptr = take ? {addr[31:7], 6'b0, chan} : m_ptr;
        n_ext = take ? {7'b0, addr[32]} : m_ext;
        n_syn = take ? syn : m_syn;
        n_rd = m_rd;
        if (rd) begin
            case (ofs)
                3'd0: n_rd = {16'h0, m_st};
                3'd1: n_rd = {16'h0, m_cmd};
                3'd2: n_rd = m_ptr;
                3'd3: n_rd = {24'h0, m_ext};
                3'd4: n_rd = {24'h0, m_syn};
                default: n_rd = 32'h0;
            endcase
        end
        @(posedge clk);
        m_serr = |(m_st & m_cmd);
        m_st = n_st; m_cmd = n_cmd; m_ptr = n_ptr; m_ext = n_ext; m_syn = n_syn; m_rd = n_rd;
        #1;
        check({tag, " rdata"}, rdata, m_rd);
        check({tag, " serr"}, {31'b0, serr}, {31'b0, m_serr});
        ce = 0; ue = 0; rf = 0; lk = 0; th = 0; wr = 0; rd = 0;
    endtask

    task automatic rd_reg(input logic [2:0] o, input string tag);
        rd = 1; ofs = o; step(tag);
    endtask

    task automatic wr_reg(input logic [2:0] o, input logic [31:0] d, input string tag);
        wr = 1; ofs = o; wdata = d; step(tag);
    endtask

    // Direct comparison of a read against a value derived from the requirement text.
    task automatic rd_expect(input logic [2:0] o, input logic [31:0] exp, input string tag);
        rd_reg(o, tag);
        check({tag, " spec"}, rdata, exp);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: every register zero after reset
        check("R1 serr", {31'b0, serr}, 32'h0);
        for (int i = 0; i < 8; i++) rd_expect(3'(i), 32'h0, "R1");

        // R5: first correctable error is captured in full
        ce = 1; addr = 33'h1_DEAD_BEEF; chan = 1; syn = 8'h5A; step("R5 ce");
        rd_expect(3'd2, 32'hDEAD_BE81, "R5 ptr");
        rd_expect(3'd3, 32'h1, "R5 ext");
        rd_expect(3'd4, 32'h5A, "R5 syn");
        rd_expect(3'd0, 32'h1, "R2 ce bit");

        // R6: second correctable error does not overwrite
        ce = 1; addr = 33'h0_1234_5600; chan = 0; syn = 8'h11; step("R6 ce2");
        rd_expect(3'd2, 32'hDEAD_BE81, "R6 ptr");
        rd_expect(3'd4, 32'h5A, "R6 syn");

        // R7: uncorrectable overwrites held correctable record
        ue = 1; addr = 33'h0_CAFE_0080; chan = 0; syn = 8'hC3; step("R7 ue");
        rd_expect(3'd2, 32'hCAFE_0080, "R7 ptr");
        rd_expect(3'd3, 32'h0, "R7 ext");
        rd_expect(3'd4, 32'hC3, "R7 syn");
        rd_expect(3'd0, 32'h3, "R2 ue bit");
        ue = 1; addr = 33'h1_0000_0F00; chan = 1; syn = 8'h77; step("R7 ue2");
        rd_expect(3'd2, 32'hCAFE_0080, "R7 ue held");
        ce = 1; addr = 33'h0_5555_5555; syn = 8'h01; step("R6 ce after ue");
        rd_expect(3'd4, 32'hC3, "R6 syn after ue");

        // R3: write one clears, write zero keeps
        wr_reg(3'd0, 32'h0000_0001, "R3 clr ce");
        rd_expect(3'd0, 32'h2, "R3 ce cleared");
        wr_reg(3'd0, 32'h0, "R3 zero");
        rd_expect(3'd0, 32'h2, "R3 zero keeps");

        // R2: other events and reserved bits
        rf = 1; step("R2 rf"); lk = 1; step("R2 lk"); th = 1; step("R2 th");
        rd_expect(3'd0, 32'h0B02, "R2 all");
        wr_reg(3'd0, 32'hFFFF_FFFF, "R3 clr all");
        rd_expect(3'd0, 32'h0, "R3 all clear");

        // R7: both pulses together capture as uncorrectable
        ce = 1; ue = 1; addr = 33'h0_0000_0100; chan = 1; syn = 8'h99; step("R7 both");
        rd_expect(3'd2, 32'h0000_0101, "R7 both ptr");
        wr_reg(3'd0, 32'h3, "R3 clr ecc");

        // R4: clear and new event in the same cycle, new event wins
        ce = 1; wr = 1; ofs = 3'd0; wdata = 32'h1; step("R4 same cycle");
        rd_expect(3'd0, 32'h1, "R4 stays set");

        // R8: command register and system-error output
        wr_reg(3'd1, 32'hFFFF_FFFF, "R8 cmd");
        rd_expect(3'd1, 32'h0B03, "R8 cmd mask");
        step("R8 serr");
        check("R8 serr high", {31'b0, serr}, 32'h1);
        wr_reg(3'd0, 32'h1, "R8 clr");
        step("R8 settle");
        check("R8 serr low", {31'b0, serr}, 32'h0);

        // R9: read-only and unmapped offsets
        wr_reg(3'd2, 32'h1234_5678, "R9 ptr wr");
        wr_reg(3'd4, 32'hFF, "R9 syn wr");
        wr_reg(3'd6, 32'hFFFF, "R9 unmapped wr");
        rd_expect(3'd2, 32'h0000_0101, "R9 ptr ro");
        rd_expect(3'd4, 32'h99, "R9 syn ro");
        rd_expect(3'd5, 32'h0, "R9 unmapped");
        step("R9 hold");
        check("R9 hold", rdata, 32'h0);

        // Mixed stimulus against the model (R2 to R9).
        for (int n = 0; n < 2000; n++) begin
            ce = ($urandom_range(0, 7) == 0);
            ue = ($urandom_range(0, 15) == 0);
            rf = ($urandom_range(0, 31) == 0);
            lk = ($urandom_range(0, 31) == 0);
            th = ($urandom_range(0, 31) == 0);
            addr = {$urandom_range(0, 1) == 1, 32'($urandom)};
            chan = $urandom_range(0, 1) == 1;
            syn = 8'($urandom);
            wr = ($urandom_range(0, 5) == 0);
            rd = ($urandom_range(0, 1) == 1);
            ofs = 3'($urandom_range(0, 7));
            wdata = $urandom;
            step("R7 mix");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule